// File: doc/BRIEF.md
# Multi-Sector Erase Command Collector

This block is the command front end of a NOR-style flash device. It watches bus write cycles, which are given by chip enable, write enable, address and data, and recognises the six-write unlock sequence that requests a sector erase. After the sequence it keeps an acceptance window open. Each further sector-erase write inside the window adds one sector to a 128-entry selection set and restarts the window. When the window runs out with no new write, the block erases every selected sector in turn, lowest number first. Each sector first goes through a preprogram phase and then through an erase phase.

While work is pending, a read whose address falls in a selected sector returns a status byte instead of array data. Bit 7 is 0 while the sector is pending. Bit 6 flips on every read cycle. Bit 3 is 0 while the window is open and 1 once erasure has begun. Any other read returns 8'h80. Each finished sector is announced by a one-cycle strobe that carries its number.

States and transitions: `S_READ` goes to `S_U1` on AAh written to 555h. `S_U1` goes to `S_U2` on 55h to 2AAh. `S_U2` goes to `S_U3` on 80h to 555h. `S_U3` goes to `S_U4` on AAh to 555h. `S_U4` goes to `S_U5` on 55h to 2AAh. `S_U5` goes to `S_WIN` on 30h to any address. Any other write in `S_U1` to `S_U5` goes back to `S_READ`. `S_WIN` stays in `S_WIN` on a 30h or B0h write, which also restarts the timer. It goes to `S_READ` on any other write, which also flushes the set. It goes to `S_PRE` when the timer expires. `S_PRE` goes to `S_ERS` when the preprogram count ends. `S_ERS` goes to `S_PRE` for the next selected sector, or to `S_READ` when no selected sector is left.

Top module: `erase_collector`

## Requirements
- R1: After reset, `dout` is 8'h80 for every address and `done_stb` is low.
- R2: The writes AAh to 555h, 55h to 2AAh, 80h to 555h, AAh to 555h and 55h to 2AAh, followed by 30h, open the acceptance window. Unlock addresses are compared on `addr[10:0]`. The 30h write selects the sector `addr[21:15]`.
- R3: A write that breaks the unlock sequence returns the block to read mode. The block opens no window and never strobes.
- R4: Inside the window, every 30h write adds sector `addr[21:15]` to the set. Sectors may arrive in any order, and a repeated sector is erased only once.
- R5: The window closes `WIN_CYC` cycles after the last write start. Every write start inside the window restarts it, and a B0h write does so without changing the set. Bit 3 of a status read is 0 while the window is open and 1 once erasure has begun.
- R6: Inside the window, a write with data other than 30h or B0h empties the set and returns the block to read mode. No sector is then erased.
- R7: Selected sectors are erased in ascending number order. Each one takes `PRE_CYC + ERS_CYC` cycles, and successive `done_stb` pulses are exactly that far apart. `done_sec` carries the finished sector.
- R8: A sector that was never selected is never strobed.
- R9: A read of a pending sector returns bit 7 = 0, and bit 6 flips on every read cycle. A read of any other address returns 8'h80.
- R10: After the last selected sector finishes, the block is in read mode. Reads return 8'h80 and a new unlock sequence is accepted.
- R11: Writes made while erasure runs have no effect on the set or on the order of erasure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Write data |
| dout | output | 8 | Status byte for the addressed sector |
| done_stb | output | 1 | One-cycle pulse when a sector finishes |
| done_sec | output | SEC_W | Number of the sector that finished |

## Verification
The checker watches several properties on every cycle:
- the set is never empty while the window is open;
- the sector under preprogram or erase is always a member of the set;
- every strobed sector has already left the set;
- a foreign write in the window empties the set and returns the block to read mode on the next cycle;
- read mode always shows 8'h80.

Other behaviour only the bench scenarios can show. These include the ascending erase order after out-of-order queuing, the exact spacing between strobes, and the restart of the window by writes spaced across several window lengths. They also include the rejection of broken unlock sequences and the absence of any effect from writes made during erasure.

// File: rtl/ecol_pkg.sv
package ecol_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_U1,
        S_U2,
        S_U3,
        S_U4,
        S_U5,
        S_WIN,
        S_PRE,
        S_ERS
    } ecol_state_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_PAUSE   = 8'hB0;
    localparam logic [7:0] STAT_IDLE   = 8'h80;

    localparam int UNLK_W = 11;
    localparam logic [UNLK_W-1:0] LOC_A = 11'h555;
    localparam logic [UNLK_W-1:0] LOC_B = 11'h2AA;

endpackage

// File: rtl/ecol_bus_cycle.sv
module ecol_bus_cycle (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_go,
    output logic rd_go
);
    logic wr_act, rd_act, wr_q, rd_q;

    assign wr_act = !ce_n && !we_n;
    assign rd_act = !ce_n && !oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_go = wr_act && !wr_q;
    assign rd_go = rd_act && !rd_q;
endmodule

// File: rtl/ecol_countdown.sv
module ecol_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ecol_sector_set.sv
module ecol_sector_set #(
    parameter int SEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             set_en,
    input  logic [SEC_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [SEC_W-1:0] clr_idx,
    input  logic [SEC_W-1:0] excl_idx,
    output logic [(1<<SEC_W)-1:0] bits,
    output logic             any_all,
    output logic [SEC_W-1:0] first_all,
    output logic             any_excl,
    output logic [SEC_W-1:0] first_excl
);
    localparam int N_SEC = 1 << SEC_W;

    logic [N_SEC-1:0] bits_q, rest;

    function automatic logic [SEC_W-1:0] lowest(input logic [N_SEC-1:0] v);
        lowest = '0;
        for (int i = N_SEC - 1; i >= 0; i--) begin
            if (v[i]) lowest = SEC_W'(i);
        end
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (flush) begin
            bits_q <= '0;
        end else begin
            if (set_en) bits_q[set_idx] <= 1'b1;
            if (clr_en) bits_q[clr_idx] <= 1'b0;
        end
    end

    assign rest       = bits_q & ~(N_SEC'(1) << excl_idx);
    assign bits       = bits_q;
    assign any_all    = |bits_q;
    assign first_all  = lowest(bits_q);
    assign any_excl   = |rest;
    assign first_excl = lowest(rest);
endmodule

// File: rtl/erase_collector.sv
module erase_collector
    import ecol_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int SEC_W   = 7,
    parameter int WIN_CYC = 2000,
    parameter int PRE_CYC = 64,
    parameter int ERS_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              done_stb,
    output logic [SEC_W-1:0]  done_sec
);
    localparam int N_SEC  = 1 << SEC_W;
    localparam int MAX_A  = (WIN_CYC > PRE_CYC) ? WIN_CYC : PRE_CYC;
    localparam int MAX_C  = (MAX_A > ERS_CYC) ? MAX_A : ERS_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    ecol_state_e state, nxt;

    logic              wr_go, rd_go, tmr_zero, tmr_ld;
    logic [CNT_W-1:0]  tmr_val;
    logic              set_en, clr_en, flush;
    logic [N_SEC-1:0]  sel_bits;
    logic              any_all, any_excl;
    logic [SEC_W-1:0]  first_all, first_excl;
    logic [SEC_W-1:0]  cur_sec, cur_nxt, wr_sec, rd_sec;
    logic              stb_nxt, tog_q, busy, hit;
    logic              at_a, at_b, unused_mid;

    assign wr_sec     = addr[ADDR_W-1 -: SEC_W];
    assign rd_sec     = addr[ADDR_W-1 -: SEC_W];
    assign at_a       = (addr[UNLK_W-1:0] == LOC_A);
    assign at_b       = (addr[UNLK_W-1:0] == LOC_B);
    assign unused_mid = ^addr[ADDR_W-SEC_W-1:UNLK_W];

    ecol_bus_cycle u_bus (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_go(wr_go), .rd_go(rd_go)
    );

    ecol_countdown #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val),
        .zero(tmr_zero)
    );

    ecol_sector_set #(.SEC_W(SEC_W)) u_set (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set_en(set_en), .set_idx(wr_sec),
        .clr_en(clr_en), .clr_idx(cur_sec), .excl_idx(cur_sec),
        .bits(sel_bits), .any_all(any_all), .first_all(first_all),
        .any_excl(any_excl), .first_excl(first_excl)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_READ;
        else        state <= nxt;
    end

    // next state and datapath controls
    always_comb begin
        nxt     = state;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        set_en  = 1'b0;
        clr_en  = 1'b0;
        flush   = 1'b0;
        stb_nxt = 1'b0;
        cur_nxt = cur_sec;
        unique case (state)
            S_READ: if (wr_go && din == CMD_KEY_A && at_a) nxt = S_U1;
            S_U1:   if (wr_go) nxt = (din == CMD_KEY_B && at_b) ? S_U2 : S_READ;
            S_U2:   if (wr_go) nxt = (din == CMD_SETUP && at_a) ? S_U3 : S_READ;
            S_U3:   if (wr_go) nxt = (din == CMD_KEY_A && at_a) ? S_U4 : S_READ;
            S_U4:   if (wr_go) nxt = (din == CMD_KEY_B && at_b) ? S_U5 : S_READ;
            S_U5: begin
                if (wr_go) begin
                    if (din == CMD_SECTOR) begin
                        set_en  = 1'b1;
                        tmr_ld  = 1'b1;
                        tmr_val = CNT_W'(WIN_CYC - 1);
                        nxt     = S_WIN;
                    end else begin
                        nxt = S_READ;
                    end
                end
            end
            S_WIN: begin
                if (wr_go) begin
                    if (din == CMD_SECTOR || din == CMD_PAUSE) begin
                        set_en  = (din == CMD_SECTOR);
                        tmr_ld  = 1'b1;
                        tmr_val = CNT_W'(WIN_CYC - 1);
                    end else begin
                        flush = 1'b1;
                        nxt   = S_READ;
                    end
                end else if (tmr_zero) begin
                    cur_nxt = first_all;
                    tmr_ld  = 1'b1;
                    tmr_val = CNT_W'(PRE_CYC - 1);
                    nxt     = S_PRE;
                end
            end
            S_PRE: begin
                if (tmr_zero) begin
                    tmr_ld  = 1'b1;
                    tmr_val = CNT_W'(ERS_CYC - 1);
                    nxt     = S_ERS;
                end
            end
            S_ERS: begin
                if (tmr_zero) begin
                    clr_en  = 1'b1;
                    stb_nxt = 1'b1;
                    if (any_excl) begin
                        cur_nxt = first_excl;
                        tmr_ld  = 1'b1;
                        tmr_val = CNT_W'(PRE_CYC - 1);
                        nxt     = S_PRE;
                    end else begin
                        nxt = S_READ;
                    end
                end
            end
            default: nxt = S_READ;
        endcase
    end

    assign busy = (state == S_WIN) || (state == S_PRE) || (state == S_ERS);
    assign hit  = sel_bits[rd_sec];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sec  <= '0;
            done_stb <= 1'b0;
            done_sec <= '0;
            tog_q    <= 1'b0;
        end else begin
            cur_sec  <= cur_nxt;
            done_stb <= stb_nxt;
            if (stb_nxt) done_sec <= cur_sec;
            if (rd_go && busy && hit) tog_q <= !tog_q;
        end
    end

    // status byte
    always_comb begin
        if (busy && hit) dout = {1'b0, tog_q, 2'b00, (state != S_WIN), 3'b000};
        else             dout = STAT_IDLE;
    end
endmodule

// File: rtl/ecol_checker.sv
module ecol_checker
    import ecol_pkg::*;
#(
    parameter int SEC_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ecol_state_e           state,
    input  logic                  wr_go,
    input  logic [7:0]            din,
    input  logic [(1<<SEC_W)-1:0] sel_bits,
    input  logic                  any_all,
    input  logic [SEC_W-1:0]      cur_sec,
    input  logic                  done_stb,
    input  logic [SEC_W-1:0]      done_sec,
    input  logic [7:0]            dout
);
    p_win_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WIN) |-> any_all);

    p_busy_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE || state == S_ERS) |-> sel_bits[cur_sec]);

    p_done_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |-> !sel_bits[done_sec]);

    p_foreign_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WIN && wr_go && din != CMD_SECTOR && din != CMD_PAUSE)
        |=> (state == S_READ && !any_all));

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WIN && wr_go && (din == CMD_SECTOR || din == CMD_PAUSE))
        |=> (state == S_WIN));

    p_read_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |-> (dout == STAT_IDLE));
endmodule

bind erase_collector ecol_checker #(.SEC_W(SEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_go(wr_go), .din(din),
    .sel_bits(sel_bits), .any_all(any_all), .cur_sec(cur_sec),
    .done_stb(done_stb), .done_sec(done_sec), .dout(dout)
);

// File: tb/erase_collector_bench.sv
module erase_collector_bench;
    localparam int CLK_PER = 10;
    localparam int ADDR_W  = 22;
    localparam int SEC_W   = 7;
    localparam int WIN_CYC = 20;
    localparam int PRE_CYC = 6;
    localparam int ERS_CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic done_stb;
    logic [SEC_W-1:0] done_sec;

    int total = 0, bad = 0, cyc = 0, last_cyc = 0;
    bit have_prev = 0;
    int exp_q[$];
    logic [127:0] sel_model;

    always #(CLK_PER/2) clk = ~clk;

    erase_collector #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .WIN_CYC(WIN_CYC),
                      .PRE_CYC(PRE_CYC), .ERS_CYC(ERS_CYC)) u_erase_collector (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .done_stb(done_stb), .done_sec(done_sec)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] sec_addr(int s);
        return ADDR_W'(s) << (ADDR_W - SEC_W);
    endfunction

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); v = dout; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(22'h555, 8'hAA);
        bus_write(22'h2AA, 8'h55);
        bus_write(22'h555, 8'h80);
        bus_write(22'h555, 8'hAA);
        bus_write(22'h2AA, 8'h55);
    endtask

    // driver: queue expected strobes in ascending sector order
    task automatic push_expected();
        for (int s = 0; s < 128; s++) if (sel_model[s]) exp_q.push_back(s);
        sel_model = '0;
    endtask

    task automatic wait_drain(string req);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(req, 8'(exp_q.size()), 8'd0);
        exp_q.delete();
        have_prev = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n && done_stb) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R8: actual strobe sector=%0d expected none", done_sec);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(done_sec) != e) begin
                    bad++;
                    $display("FAIL R7: actual sector=%0d expected=%0d", done_sec, e);
                end
                if (have_prev) begin
                    total++;
                    if (cyc - last_cyc != PRE_CYC + ERS_CYC) begin
                        bad++;
                        $display("FAIL R7: actual spacing=%0d expected=%0d",
                                 cyc - last_cyc, PRE_CYC + ERS_CYC);
                    end
                end
                have_prev = (exp_q.size() != 0);
                last_cyc  = cyc;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        sel_model = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", dout, 8'h80);
        chk("R1", {7'd0, done_stb}, 8'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(sec_addr(5), v);
        chk("R1", v, 8'h80);

        // R2 single sector, window status then erase status
        unlock();
        bus_write(sec_addr(5) | 22'h123, 8'h30);
        sel_model[5] = 1'b1; push_expected();
        bus_read(sec_addr(5), v);
        chk("R5", v & 8'h88, 8'h00);
        bus_read(sec_addr(5), v2);
        chk("R9", (v ^ v2) & 8'h40, 8'h40);
        bus_read(sec_addr(9), v);
        chk("R9", v, 8'h80);
        repeat (WIN_CYC + 2) @(negedge clk);
        bus_read(sec_addr(5), v);
        chk("R5", v & 8'h88, 8'h08);
        wait_drain("R2");
        bus_read(sec_addr(5), v);
        chk("R10", v, 8'h80);

        // R4 out-of-order queue, B0h and a duplicate, R11 write during erase
        unlock();
        bus_write(sec_addr(100), 8'h30);
        bus_write(sec_addr(3), 8'h30);
        bus_write(22'h0, 8'hB0);
        bus_write(sec_addr(127), 8'h30);
        bus_write(sec_addr(0), 8'h30);
        bus_write(sec_addr(3), 8'h30);
        sel_model[100] = 1; sel_model[3] = 1; sel_model[127] = 1; sel_model[0] = 1;
        push_expected();
        repeat (WIN_CYC + 2) @(negedge clk);
        bus_write(sec_addr(50), 8'h30);
        unlock();
        bus_read(sec_addr(127), v);
        chk("R11", v & 8'h88, 8'h08);
        bus_read(sec_addr(50), v);
        chk("R11", v, 8'h80);
        wait_drain("R4");

        // R6 foreign command inside the window
        unlock();
        bus_write(sec_addr(7), 8'h30);
        bus_write(sec_addr(8), 8'h30);
        bus_write(22'h0, 8'hF0);
        bus_read(sec_addr(7), v);
        chk("R6", v, 8'h80);
        repeat (WIN_CYC + 3 * (PRE_CYC + ERS_CYC)) @(negedge clk);
        wait_drain("R6");

        // R3 broken unlock sequence
        bus_write(22'h555, 8'hAA);
        bus_write(22'h2AA, 8'h55);
        bus_write(22'h555, 8'h90);
        bus_write(22'h555, 8'hAA);
        bus_write(22'h2AA, 8'h55);
        bus_write(sec_addr(2), 8'h30);
        bus_read(sec_addr(2), v);
        chk("R3", v, 8'h80);
        bus_write(22'h555, 8'hAA);
        bus_write(22'h2AA, 8'h54);
        bus_write(22'h555, 8'h80);
        repeat (WIN_CYC + 2 * (PRE_CYC + ERS_CYC)) @(negedge clk);
        wait_drain("R3");

        // R5 window kept open by spaced writes
        unlock();
        bus_write(sec_addr(10), 8'h30);
        sel_model[10] = 1; push_expected();
        for (int k = 0; k < 4; k++) begin
            repeat (WIN_CYC - 8) @(negedge clk);
            bus_write(22'h0, 8'hB0);
        end
        bus_read(sec_addr(10), v);
        chk("R5", v & 8'h88, 8'h00);
        wait_drain("R5");

        // R10 new sequence after completion
        unlock();
        bus_write(sec_addr(64), 8'h30);
        sel_model[64] = 1; push_expected();
        wait_drain("R10");
        bus_read(sec_addr(64), v);
        chk("R10", v, 8'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule